// File: doc/BRIEF.md
# E1 Signaling Multiframe Alignment Monitor

This block watches the signaling time slot (time slot 16) of a received E1 stream. It finds and then supervises the 16-frame channel-associated signaling multiframe. An upstream framer supplies one received bit per clock, together with the time slot number (0..31) and the bit number inside the slot (0..7). Bit number 0 carries octet bit 1, the first bit received, which becomes the MSB of the captured octet. The framer also supplies a flag that is high while basic frame alignment holds.

The block is built around a three-state machine:
- **ST_IDLE**: basic frame alignment is absent.
- **ST_HUNT**: the block searches for the multiframe pattern.
- **ST_SYNC**: the multiframe is aligned and the block counts frames 0..15.

The transitions are:
- IDLE→HUNT when basic alignment appears.
- HUNT→SYNC on acquisition.
- SYNC→HUNT on an errored-pattern pair or on a long all-zero run.
- HUNT→IDLE and SYNC→IDLE when basic alignment drops.

While aligned, the block passes on the received spare control bits and the remote multiframe alarm bit from each frame-0 signaling octet, and it enables signaling updates. While alignment is lost, those outputs are forced to fixed values. Two configuration bits then turn on transmit-side alarm requests. A sticky loss-event flag records each exit from ST_SYNC.

Top module: `e1_sigmf_align`

## Requirements
- R1: After reset the block is unlocked. The frame index is 0, the control-bit output is 3'b111, the alarm output is 0, the update enable is 0 and the loss-event flag is 0.
- R2: In ST_HUNT, alignment is acquired and the frame index set to 0 when a slot-16 octet has its four leading bits (octet bits 1-4, MSBs [7:4]) all zero and the previous slot-16 octet held at least one 1 bit.
- R3: No acquisition happens when the previous slot-16 octet was all zero, nor while basic alignment is low. The one-octet history is cleared while basic alignment is absent.
- R4: While aligned, the frame index increases by one at every slot-16 octet and wraps from 15 to 0. Only frame 0 is checked for the 0000 pattern.
- R5: A single frame-0 octet with a nonzero pattern keeps alignment. Two consecutive checked frame-0 octets with nonzero patterns drop to ST_HUNT.
- R6: 32 consecutive all-zero slot-16 octets after acquisition drop alignment. 31 do not.
- R7: With basic alignment low, the locked output is 0 in the same cycle, and the machine enters ST_IDLE at the next clock.
- R8: While locked, the update enable is 1. The control-bit output is {bit5, bit7, bit8} = {octet[3], octet[1], octet[0]}, and the alarm output is bit6 = octet[2], both taken from the latest frame-0 octet.
- R9: While unlocked, the control-bit output is 3'b111, and the alarm output and the update enable are 0.
- R10: The remote alarm request equals (unlocked AND its enable). The slot-16 AIS request equals (unlocked AND its enable).
- R11: The loss-event flag is set whenever ST_SYNC is left and stays set until a clear pulse. When a clear and a new loss fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one received bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received data bit |
| ts_idx | input | 5 | Time slot number of rx_bit |
| bit_idx | input | 3 | Bit number inside the slot, 0 = octet bit 1 |
| bfa_ok | input | 1 | Basic frame alignment present |
| cfg_rma_en | input | 1 | Enable remote alarm request while unlocked |
| cfg_ais_en | input | 1 | Enable slot-16 AIS request while unlocked |
| clr_evt | input | 1 | Clear pulse for the loss-event flag |
| mf_locked | output | 1 | Multiframe aligned |
| mf_idx | output | 4 | Current multiframe frame index |
| sig_upd_en | output | 1 | Signaling store update enable |
| rx_ctrl | output | 3 | Received control bits {b5,b7,b8} |
| rx_rma | output | 1 | Received remote multiframe alarm bit |
| tx_rma_req | output | 1 | Request remote alarm toward line |
| tx_ais_req | output | 1 | Request all-ones system slot 16 |
| loss_evt | output | 1 | Sticky alignment-loss event |

## Verification
The clear pulse for the loss-event flag and a new alignment loss can fall in the same clock cycle. The bench provokes this by dropping basic alignment while locked and pulsing the clear in the same cycle. It then expects the flag to read 1 afterwards, because a set must win over a clear. A second coincidence, a frame-0 pattern error arriving at the end of a long zero run, is avoided by the stimulus. Each loss trigger is therefore judged on its own.

// File: rtl/sigmf_pkg.sv
package sigmf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_SYNC = 2'd2
    } mfa_state_t;

    localparam logic [2:0] CTRL_FORCED = 3'b111;
    localparam logic       RMA_FORCED  = 1'b0;
endpackage

// File: rtl/sigmf_octet_cap.sv
module sigmf_octet_cap #(
    parameter int NUM_TS  = 32,
    parameter int SIG_TS  = 16,
    parameter int OCT_W   = 8,
    localparam int TSW    = $clog2(NUM_TS),
    localparam int BW     = $clog2(OCT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic [TSW-1:0]   ts_idx,
    input  logic [BW-1:0]    bit_idx,
    output logic             oct_vld,
    output logic [OCT_W-1:0] octet
);
    logic [OCT_W-1:0] shreg;
    logic             in_sig;
    logic             last_bit;

    assign in_sig   = (ts_idx == TSW'(SIG_TS));
    assign last_bit = in_sig && (bit_idx == BW'(OCT_W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            octet   <= '0;
            oct_vld <= 1'b0;
        end else begin
            oct_vld <= last_bit;
            if (in_sig)
                shreg <= {shreg[OCT_W-2:0], rx_bit};
            if (last_bit)
                octet <= {shreg[OCT_W-2:0], rx_bit};
        end
    end
endmodule

// File: rtl/sigmf_fsm.sv
module sigmf_fsm
    import sigmf_pkg::*;
#(
    parameter int MF_LEN  = 16,
    parameter int OCT_W   = 8,
    parameter int PAT_W   = 4,
    localparam int IDXW   = $clog2(MF_LEN),
    localparam int ZSPAN  = 2 * MF_LEN,
    localparam int ZW     = $clog2(ZSPAN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bfa_ok,
    input  logic             oct_vld,
    input  logic [OCT_W-1:0] octet,
    output mfa_state_t       state,
    output logic [IDXW-1:0]  mf_idx,
    output logic             locked,
    output logic             fr0_hit,
    output logic             lose_ev
);
    mfa_state_t      nxt;
    logic            prev_one;
    logic            err_prev;
    logic [ZW-1:0]   zcnt;
    logic [IDXW-1:0] nxt_idx;
    logic            pat_zero, all_zero, is_chk, acquire, err_loss, zero_loss;

    assign nxt_idx   = mf_idx + IDXW'(1);
    assign pat_zero  = (octet[OCT_W-1 -: PAT_W] == '0);
    assign all_zero  = (octet == '0);
    assign is_chk    = (state == ST_SYNC) && oct_vld && (nxt_idx == '0);
    assign acquire   = (state == ST_HUNT) && bfa_ok && oct_vld && pat_zero && prev_one;
    assign err_loss  = is_chk && !pat_zero && err_prev;
    assign zero_loss = (state == ST_SYNC) && oct_vld && all_zero && (zcnt == ZW'(ZSPAN - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (bfa_ok) nxt = ST_HUNT;
            ST_HUNT: begin
                if (!bfa_ok)      nxt = ST_IDLE;
                else if (acquire) nxt = ST_SYNC;
            end
            ST_SYNC: begin
                if (!bfa_ok)                    nxt = ST_IDLE;
                else if (err_loss || zero_loss) nxt = ST_HUNT;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mf_idx   <= '0;
            prev_one <= 1'b0;
            err_prev <= 1'b0;
            zcnt     <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE || !bfa_ok)
                prev_one <= 1'b0;
            else if (oct_vld)
                prev_one <= !all_zero;
            if (acquire) begin
                mf_idx   <= '0;
                err_prev <= 1'b0;
                zcnt     <= '0;
            end else if (state == ST_SYNC && oct_vld) begin
                mf_idx <= nxt_idx;
                zcnt   <= all_zero ? zcnt + ZW'(1) : '0;
                if (is_chk)
                    err_prev <= !pat_zero;
            end
        end
    end

    always_comb begin
        locked  = (state == ST_SYNC) && bfa_ok;
        fr0_hit = acquire || is_chk;
        lose_ev = (state == ST_SYNC) && (!bfa_ok || err_loss || zero_loss);
    end
endmodule

// File: rtl/sigmf_out.sv
module sigmf_out
    import sigmf_pkg::*;
#(
    parameter int OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             fr0_hit,
    input  logic             lose_ev,
    input  logic [OCT_W-1:0] octet,
    input  logic             cfg_rma_en,
    input  logic             cfg_ais_en,
    input  logic             clr_evt,
    output logic             sig_upd_en,
    output logic [2:0]       rx_ctrl,
    output logic             rx_rma,
    output logic             tx_rma_req,
    output logic             tx_ais_req,
    output logic             loss_evt
);
    logic [2:0] cap_ctrl;
    logic       cap_rma;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ctrl <= CTRL_FORCED;
            cap_rma  <= RMA_FORCED;
            loss_evt <= 1'b0;
        end else begin
            if (fr0_hit) begin
                cap_ctrl <= {octet[3], octet[1], octet[0]};
                cap_rma  <= octet[2];
            end
            if (lose_ev)
                loss_evt <= 1'b1;
            else if (clr_evt)
                loss_evt <= 1'b0;
        end
    end

    always_comb begin
        sig_upd_en = locked;
        rx_ctrl    = locked ? cap_ctrl : CTRL_FORCED;
        rx_rma     = locked ? cap_rma  : RMA_FORCED;
        tx_rma_req = !locked && cfg_rma_en;
        tx_ais_req = !locked && cfg_ais_en;
    end
endmodule

// File: rtl/e1_sigmf_align.sv
module e1_sigmf_align
    import sigmf_pkg::*;
#(
    parameter int NUM_TS = 32,
    parameter int SIG_TS = 16,
    parameter int MF_LEN = 16,
    parameter int OCT_W  = 8,
    parameter int PAT_W  = 4,
    localparam int TSW   = $clog2(NUM_TS),
    localparam int BW    = $clog2(OCT_W),
    localparam int IDXW  = $clog2(MF_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_bit,
    input  logic [TSW-1:0]  ts_idx,
    input  logic [BW-1:0]   bit_idx,
    input  logic            bfa_ok,
    input  logic            cfg_rma_en,
    input  logic            cfg_ais_en,
    input  logic            clr_evt,
    output logic            mf_locked,
    output logic [IDXW-1:0] mf_idx,
    output logic            sig_upd_en,
    output logic [2:0]      rx_ctrl,
    output logic            rx_rma,
    output logic            tx_rma_req,
    output logic            tx_ais_req,
    output logic            loss_evt
);
    logic             oct_vld;
    logic [OCT_W-1:0] octet;
    mfa_state_t       state;
    logic             fr0_hit;
    logic             lose_ev;

    sigmf_octet_cap #(.NUM_TS(NUM_TS), .SIG_TS(SIG_TS), .OCT_W(OCT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .ts_idx(ts_idx),
        .bit_idx(bit_idx), .oct_vld(oct_vld), .octet(octet)
    );

    sigmf_fsm #(.MF_LEN(MF_LEN), .OCT_W(OCT_W), .PAT_W(PAT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bfa_ok(bfa_ok), .oct_vld(oct_vld),
        .octet(octet), .state(state), .mf_idx(mf_idx), .locked(mf_locked),
        .fr0_hit(fr0_hit), .lose_ev(lose_ev)
    );

    sigmf_out #(.OCT_W(OCT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .locked(mf_locked), .fr0_hit(fr0_hit),
        .lose_ev(lose_ev), .octet(octet), .cfg_rma_en(cfg_rma_en),
        .cfg_ais_en(cfg_ais_en), .clr_evt(clr_evt), .sig_upd_en(sig_upd_en),
        .rx_ctrl(rx_ctrl), .rx_rma(rx_rma), .tx_rma_req(tx_rma_req),
        .tx_ais_req(tx_ais_req), .loss_evt(loss_evt)
    );
endmodule

// File: rtl/e1_sigmf_align_chk.sv
module e1_sigmf_align_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bfa_ok,
    input logic       cfg_rma_en,
    input logic       cfg_ais_en,
    input logic       mf_locked,
    input logic [3:0] mf_idx,
    input logic       sig_upd_en,
    input logic [2:0] rx_ctrl,
    input logic       rx_rma,
    input logic       tx_rma_req,
    input logic       tx_ais_req,
    input logic       loss_evt
);
    p_bfa_unlock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bfa_ok |-> !mf_locked);

    p_forced_outs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_locked |-> (rx_ctrl == 3'b111 && !rx_rma && !sig_upd_en));

    p_upd_when_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mf_locked |-> sig_upd_en);

    p_tx_req_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rma_req || tx_ais_req) |-> !mf_locked);

    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_locked && $past(mf_locked) && mf_idx != $past(mf_idx))
            |-> mf_idx == $past(mf_idx) + 4'd1);

    p_acq_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf_locked) |-> mf_idx == 4'd0);

    p_evt_on_unlock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_evt) |-> !mf_locked);
endmodule

bind e1_sigmf_align e1_sigmf_align_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bfa_ok(bfa_ok), .cfg_rma_en(cfg_rma_en),
    .cfg_ais_en(cfg_ais_en), .mf_locked(mf_locked), .mf_idx(mf_idx),
    .sig_upd_en(sig_upd_en), .rx_ctrl(rx_ctrl), .rx_rma(rx_rma),
    .tx_rma_req(tx_rma_req), .tx_ais_req(tx_ais_req), .loss_evt(loss_evt)
);

// File: tb/e1_sigmf_align_bench.sv
module e1_sigmf_align_bench;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0;
    logic [4:0] ts_idx = '0;
    logic [2:0] bit_idx = '0;
    logic       bfa_ok = 1'b0;
    logic       cfg_rma_en = 1'b0;
    logic       cfg_ais_en = 1'b0;
    logic       clr_evt = 1'b0;
    logic       mf_locked, sig_upd_en, rx_rma, tx_rma_req, tx_ais_req, loss_evt;
    logic [3:0] mf_idx;
    logic [2:0] rx_ctrl;

    int total = 0;
    int bad = 0;

    always #(CLK_PER/2) clk = ~clk;

    e1_sigmf_align u_e1_sigmf_align (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .ts_idx(ts_idx),
        .bit_idx(bit_idx), .bfa_ok(bfa_ok), .cfg_rma_en(cfg_rma_en),
        .cfg_ais_en(cfg_ais_en), .clr_evt(clr_evt), .mf_locked(mf_locked),
        .mf_idx(mf_idx), .sig_upd_en(sig_upd_en), .rx_ctrl(rx_ctrl),
        .rx_rma(rx_rma), .tx_rma_req(tx_rma_req), .tx_ais_req(tx_ais_req),
        .loss_evt(loss_evt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] t16);
        for (int ts = 0; ts < 32; ts++) begin
            for (int b = 0; b < 8; b++) begin
                ts_idx  = 5'(ts);
                bit_idx = 3'(b);
                rx_bit  = (ts == 16) ? t16[7-b] : 1'b0;
                @(negedge clk);
            end
        end
    endtask

    task automatic send_fill(input int n);
        for (int i = 0; i < n; i++) send_frame(8'h55);
    endtask

    task automatic pulse_clear();
        clr_evt = 1'b1;
        @(negedge clk);
        clr_evt = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 locked", mf_locked, 0);
        check("R1 idx", mf_idx, 0);
        check("R1 ctrl", rx_ctrl, 3'b111);
        check("R1 rma", rx_rma, 0);
        check("R1 upd", sig_upd_en, 0);
        check("R1 evt", loss_evt, 0);
    endtask

    task automatic t_acquire();
        bfa_ok = 1'b1;
        send_frame(8'hFF);
        check("R2 no lock on nonzero pattern", mf_locked, 0);
        send_frame(8'h05);
        check("R2 locked", mf_locked, 1);
        check("R2 idx zero", mf_idx, 0);
        check("R8 ctrl", rx_ctrl, 3'b001);
        check("R8 rma", rx_rma, 1);
        check("R8 upd", sig_upd_en, 1);
    endtask

    task automatic t_index();
        for (int i = 1; i < 16; i++) begin
            send_frame(8'h55);
            check("R4 idx step", mf_idx, 32'(i));
        end
        send_frame(8'h0A);
        check("R4 wrap", mf_idx, 0);
        check("R8 ctrl update", rx_ctrl, 3'b110);
        check("R8 rma update", rx_rma, 0);
    endtask

    task automatic t_pattern_err();
        cfg_rma_en = 1'b1;
        send_fill(15);
        send_frame(8'h8A);
        check("R5 single error keeps lock", mf_locked, 1);
        send_fill(15);
        send_frame(8'h0A);
        check("R5 good pattern keeps lock", mf_locked, 1);
        send_fill(15);
        send_frame(8'h8A);
        check("R5 first of pair", mf_locked, 1);
        send_fill(15);
        send_frame(8'h8A);
        check("R5 pair drops lock", mf_locked, 0);
        check("R11 evt set", loss_evt, 1);
        check("R9 ctrl forced", rx_ctrl, 3'b111);
        check("R9 rma forced", rx_rma, 0);
        check("R9 upd off", sig_upd_en, 0);
        check("R10 rma req", tx_rma_req, 1);
        check("R10 ais req off", tx_ais_req, 0);
        cfg_ais_en = 1'b1;
        #1;
        check("R10 ais req on", tx_ais_req, 1);
        pulse_clear();
        check("R11 cleared", loss_evt, 0);
    endtask

    task automatic t_zero_run();
        send_frame(8'hFF);
        send_frame(8'h0A);
        check("R2 relock", mf_locked, 1);
        check("R10 req off when locked", tx_rma_req, 0);
        for (int i = 0; i < 31; i++) send_frame(8'h00);
        check("R6 31 zeros keep lock", mf_locked, 1);
        send_frame(8'h00);
        check("R6 32 zeros drop", mf_locked, 0);
        check("R11 evt after zeros", loss_evt, 1);
        pulse_clear();
    endtask

    task automatic t_bfa();
        send_frame(8'hFF);
        send_frame(8'h0A);
        check("R2 lock before bfa test", mf_locked, 1);
        check("R11 evt clear before", loss_evt, 0);
        bfa_ok  = 1'b0;
        clr_evt = 1'b1;
        #1;
        check("R7 immediate unlock", mf_locked, 0);
        @(negedge clk);
        clr_evt = 1'b0;
        check("R11 set wins over clear", loss_evt, 1);
        send_frame(8'hFF);
        send_frame(8'h0A);
        check("R3 no lock without bfa", mf_locked, 0);
        bfa_ok = 1'b1;
        send_frame(8'h00);
        send_frame(8'h00);
        check("R3 no lock after zero octet", mf_locked, 0);
        send_frame(8'h05);
        check("R3 still no lock", mf_locked, 0);
        send_frame(8'h05);
        check("R3 lock after one-bearing octet", mf_locked, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_acquire();
        t_index();
        t_pattern_err();
        t_zero_run();
        t_bfa();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule